// File: doc/BRIEF.md
# Processor Data Bus Parity Generator with Error Injection and Machine-Check Routing

This block sits on the data path that a bus bridge uses to drive a 64-bit processor data bus. Each cycle the bridge sources data, it registers the data with one odd-parity bit for each byte lane. Test software can set a per-lane corruption mask, and each selected lane then carries inverted parity. This exercises the parity checkers downstream. Corruption only happens while the processor bus parity mode is on.

The block also turns error events into two active-low machine-check outputs. An error that carries a known master ID asserts the output that matches that ID. An error flagged as having no known master asserts the output picked by a default-master bit. The unknown-master case covers errors where the bridge itself mastered the processor transfer, and PCI parity errors on transactions that did not involve the bridge's own PCI master. A machine check stays asserted until software writes a clear strobe for that output.

Top module: `dbus_parity_guard`

## Requirements
- R1: Each lane parity bit makes its lane plus that bit hold an odd number of ones. Lane 0 covers the most significant byte (data[63:56]) and lane 7 covers data[7:0]. The parity and the data appear on the outputs one clock after `dout_en` is sampled high.
- R2: While `par_mode` is 1, setting mask bit n (register bit n, n = 0..7) inverts the parity of lane n only. Every other lane stays correct.
- R3: While `par_mode` is 0, the mask is ignored and all lanes carry correct parity.
- R4: In a cycle after `dout_en` was sampled low, `bus_drv` is 0 and every parity bit is 1 (the idle value).
- R5: An error event with `err_unknown`=0 asserts the machine check whose index equals `err_master`. The default-master bit has no effect on it.
- R6: An error event with `err_unknown`=1 asserts machine check 1 when the default-master bit (register bit 8) is 1, and machine check 0 when it is 0.
- R7: A machine check stays low until a register write sets its clear bit (bit 9 clears output 0, bit 10 clears output 1). A new error in the same cycle as the clear keeps the output asserted.
- R8: After reset, the mask and the default-master bit are 0, both machine checks are high, and the parity bits show the idle value.
- R9: The register read port returns the mask in bits 7:0 and the default-master bit in bit 8. Bits 9 and 10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 11 | Write data: mask, default-master bit, two clear strobes |
| reg_rdata | output | 11 | Register read value |
| par_mode | input | 1 | Processor data parity mode enable |
| dout_en | input | 1 | Bridge is sourcing data this cycle |
| dout | input | 64 | Data to be driven |
| bus_drv | output | 1 | Registered drive enable |
| bus_dout | output | 64 | Registered data |
| bus_dpar | output | 8 | Registered lane parity, bit n covers lane n |
| err_valid | input | 1 | Error event strobe |
| err_unknown | input | 1 | Master of the failing transfer is unknown |
| err_master | input | 1 | Master ID when known |
| mchk_n | output | 2 | Active-low machine checks, bit i is output i |

## Verification
The bench uses the default 64-bit bus with 8-bit lanes. This gives eight lanes, so all 256 corruption masks can be tried under both parity modes, each against several data patterns, with the expected lane parity counted bit by bit. The small routing space is also swept in full: every combination of the unknown flag, the master ID and the default-master bit. That sweep covers the hold, clear, and set-against-clear orderings of the machine checks.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef enum logic {
    MC_OUT0 = 1'b0,
    MC_OUT1 = 1'b1
  } mc_sel_e;

  function automatic mc_sel_e pick_target(input logic unknown,
                                          input logic master,
                                          input logic dflt);
    if (unknown) return mc_sel_e'(dflt);
    return mc_sel_e'(master);
  endfunction

endpackage

// File: rtl/dbp_rst_sync.sv
module dbp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/dbp_lane.sv
module dbp_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_data,
  input  logic              flip,
  output logic              par_bit
);

  // odd parity: the bit is 1 when the lane holds an even number of ones
  always_comb begin
    par_bit = ~(^lane_data) ^ flip;
  end

endmodule

// File: rtl/dbp_csr.sv
module dbp_csr #(
  parameter int LANES = 8,
  localparam int CSR_W = LANES + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] rdata,
  output logic [LANES-1:0] inj_q,
  output logic             dflt_q,
  output logic [1:0]       clr
);

  logic [LANES-1:0] inj_d;
  logic             dflt_d;

  always_comb begin
    inj_d  = inj_q;
    dflt_d = dflt_q;
    if (we) begin
      inj_d  = wdata[LANES-1:0];
      dflt_d = wdata[LANES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q  <= '0;
      dflt_q <= 1'b0;
    end else begin
      inj_q  <= inj_d;
      dflt_q <= dflt_d;
    end
  end

  always_comb begin
    clr[0] = we & wdata[LANES+1];
    clr[1] = we & wdata[LANES+2];
    rdata  = {2'b00, dflt_q, inj_q};
  end

  AST_RDBACK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[LANES:0] == $past(wdata[LANES:0])); // R9

  AST_RDBACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata)); // R9

endmodule

// File: rtl/dbp_mchk.sv
module dbp_mchk
  import dbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_valid,
  input  logic       err_unknown,
  input  logic       err_master,
  input  logic       dflt,
  input  logic [1:0] clr,
  output logic [1:0] mchk_n
);

  mc_sel_e    target;
  logic [1:0] set_hit;
  logic [1:0] mc_d;
  logic [1:0] mc_q;

  always_comb begin
    target  = pick_target(err_unknown, err_master, dflt);
    set_hit = 2'b00;
    if (err_valid) set_hit[target] = 1'b1;
  end

  generate
    for (genvar i = 0; i < 2; i++) begin : g_out
      // a new event outranks a clear in the same cycle
      always_comb begin
        mc_d[i] = set_hit[i] | (mc_q[i] & ~clr[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc_q <= 2'b00;
    else        mc_q <= mc_d;
  end

  assign mchk_n = ~mc_q;

  AST_KNOWN_TO_0: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_unknown && !err_master) |=> !mchk_n[0]); // R5

  AST_KNOWN_TO_1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_unknown && err_master) |=> !mchk_n[1]); // R5

  AST_UNKNOWN_DFLT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_unknown) |=> !mchk_n[$past(dflt)]); // R6

  AST_HOLD_0: assert property (@(posedge clk) disable iff (!rst_n)
    (!mchk_n[0] && !clr[0]) |=> !mchk_n[0]); // R7

  AST_HOLD_1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mchk_n[1] && !clr[1]) |=> !mchk_n[1]); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && mchk_n[0] && mchk_n[1]) |=> (mchk_n == 2'b11)); // R7

endmodule

// File: rtl/dbus_parity_guard.sv
module dbus_parity_guard #(
  parameter int   DATA_W   = 64,
  parameter int   LANE_W   = 8,
  parameter logic IDLE_PAR = 1'b1,
  localparam int  LANES    = DATA_W / LANE_W,
  localparam int  CSR_W    = LANES + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [CSR_W-1:0]  reg_wdata,
  output logic [CSR_W-1:0]  reg_rdata,
  input  logic              par_mode,
  input  logic              dout_en,
  input  logic [DATA_W-1:0] dout,
  output logic              bus_drv,
  output logic [DATA_W-1:0] bus_dout,
  output logic [LANES-1:0]  bus_dpar,
  input  logic              err_valid,
  input  logic              err_unknown,
  input  logic              err_master,
  output logic [1:0]        mchk_n
);

  logic             srst_n;
  logic [LANES-1:0] inj_q;
  logic             dflt_q;
  logic [1:0]       clr;
  logic [LANES-1:0] lane_par;
  logic [LANES-1:0] par_d;
  logic [DATA_W-1:0] dout_d;
  logic             drv_d;

  dbp_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dbp_csr #(.LANES(LANES)) u_csr (
    .clk    (clk),
    .rst_n  (srst_n),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .inj_q  (inj_q),
    .dflt_q (dflt_q),
    .clr    (clr)
  );

  generate
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      localparam int HI = DATA_W - 1 - n * LANE_W;

      dbp_lane #(.LANE_W(LANE_W)) u_lane (
        .lane_data (dout[HI -: LANE_W]),
        .flip      (par_mode & inj_q[n]),
        .par_bit   (lane_par[n])
      );

      AST_LANE_CLEAN: assert property (@(posedge clk) disable iff (!srst_n)
        (dout_en && !(par_mode && inj_q[n])) |=>
          ($countones({bus_dout[HI -: LANE_W], bus_dpar[n]}) % 2 == 1)); // R3

      AST_LANE_FLIPPED: assert property (@(posedge clk) disable iff (!srst_n)
        (dout_en && par_mode && inj_q[n]) |=>
          ($countones({bus_dout[HI -: LANE_W], bus_dpar[n]}) % 2 == 0)); // R2
    end
  endgenerate

  always_comb begin
    drv_d  = dout_en;
    dout_d = bus_dout;
    par_d  = {LANES{IDLE_PAR}};
    if (dout_en) begin
      dout_d = dout;
      par_d  = lane_par;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bus_drv  <= 1'b0;
      bus_dout <= '0;
      bus_dpar <= {LANES{IDLE_PAR}};
    end else begin
      bus_drv  <= drv_d;
      bus_dout <= dout_d;
      bus_dpar <= par_d;
    end
  end

  dbp_mchk u_mchk (
    .clk         (clk),
    .rst_n       (srst_n),
    .err_valid   (err_valid),
    .err_unknown (err_unknown),
    .err_master  (err_master),
    .dflt        (dflt_q),
    .clr         (clr),
    .mchk_n      (mchk_n)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!srst_n)
    !dout_en |=> (!bus_drv && bus_dpar == {LANES{IDLE_PAR}})); // R4

  AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (!srst_n)
    dout_en |=> (bus_drv && bus_dout == $past(dout))); // R1

endmodule

// File: tb/dbus_parity_guard_bench.sv
module dbus_parity_guard_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [10:0] reg_wdata;
  logic [10:0] reg_rdata;
  logic        par_mode;
  logic        dout_en;
  logic [63:0] dout;
  logic        bus_drv;
  logic [63:0] bus_dout;
  logic [7:0]  bus_dpar;
  logic        err_valid;
  logic        err_unknown;
  logic        err_master;
  logic [1:0]  mchk_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_parity_guard u_dbus_parity_guard (
    .clk (clk), .rst_n (rst_n),
    .reg_we (reg_we), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .par_mode (par_mode), .dout_en (dout_en), .dout (dout),
    .bus_drv (bus_drv), .bus_dout (bus_dout), .bus_dpar (bus_dpar),
    .err_valid (err_valid), .err_unknown (err_unknown), .err_master (err_master),
    .mchk_n (mchk_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_par(input logic [63:0] d, input logic pm,
                                         input logic [7:0] mask);
    logic [7:0] p;
    for (int n = 0; n < 8; n++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[63 - 8*n - b]);
      p[n] = (ones % 2 == 0) ? 1'b1 : 1'b0;
      if (pm && mask[n]) p[n] = ~p[n];
    end
    return p;
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [10:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic raise_err(input logic unk, input logic m);
    err_valid = 1'b1; err_unknown = unk; err_master = m;
    tick();
    err_valid = 1'b0; err_unknown = 1'b0; err_master = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] pats [4];
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h8000_0000_0000_0001;

    rst_n = 1'b0; reg_we = 0; reg_wdata = '0; par_mode = 0; dout_en = 0;
    dout = '0; err_valid = 0; err_unknown = 0; err_master = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R8 reset state
    chk("R8 rdata", 64'(reg_rdata), 64'h0);
    chk("R8 mchk_n", 64'(mchk_n), 64'h3);
    chk("R8 idle parity", 64'(bus_dpar), 64'hFF);
    chk("R8 drv", 64'(bus_drv), 64'h0);

    // R1 R2 R3 R9: every mask, both parity modes, several data words
    for (int mask = 0; mask < 256; mask++) begin
      reg_write({3'b000, 8'(mask)});
      chk("R9 readback", 64'(reg_rdata), 64'(mask));
      for (int pm = 0; pm < 2; pm++) begin
        for (int k = 0; k < 5; k++) begin
          logic [63:0] d;
          d = (k < 4) ? pats[k] : {8{8'(mask)}} ^ 64'(mask * 64'h9E37_79B9);
          par_mode = pm[0]; dout_en = 1'b1; dout = d;
          tick();
          chk(pm[0] ? "R2 injected parity" : "R3 mask ignored",
              64'(bus_dpar), 64'(exp_par(d, pm[0], 8'(mask))));
          chk("R1 data", bus_dout, d);
        end
      end
      dout_en = 1'b0; dout = '1;
      tick();
      chk("R4 idle parity", 64'(bus_dpar), 64'hFF);
      chk("R4 drv low", 64'(bus_drv), 64'h0);
    end
    par_mode = 1'b0;

    // R5 R6 R7: routing sweep
    for (int dl = 0; dl < 2; dl++) begin
      for (int unk = 0; unk < 2; unk++) begin
        for (int m = 0; m < 2; m++) begin
          int idx;
          logic [1:0] exp_n;
          idx = unk ? dl : m;
          exp_n = ~(2'b01 << idx);
          reg_write({2'b11, dl[0], 8'h00});
          chk("R7 cleared", 64'(mchk_n), 64'h3);
          raise_err(unk[0], m[0]);
          chk(unk ? "R6 unknown route" : "R5 known route", 64'(mchk_n), 64'(exp_n));
          repeat (3) tick();
          chk("R7 held", 64'(mchk_n), 64'(exp_n));
          // clear the other output: no effect on this one
          reg_write({(idx == 0) ? 2'b10 : 2'b01, dl[0], 8'h00});
          chk("R7 other clear", 64'(mchk_n), 64'(exp_n));
          // set and clear together: stays asserted
          err_valid = 1'b1; err_unknown = unk[0]; err_master = m[0];
          reg_we = 1'b1; reg_wdata = {(idx == 0) ? 2'b01 : 2'b10, dl[0], 8'h00};
          tick();
          err_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
          chk("R7 set beats clear", 64'(mchk_n), 64'(exp_n));
          chk("R9 clear bits read 0", 64'(reg_rdata[10:9]), 64'h0);
        end
      end
    end
    reg_write(11'b110_0000_0000);
    chk("R7 final clear", 64'(mchk_n), 64'h3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule